// File: doc/BRIEF.md
# SPI master with FIFOs

This block is a serial master controller that a processor reaches through a small 32-bit register bus. Software sets a word size of 1 to 16 bits and a serial clock divider, then writes words into an eight-entry transmit queue. A shift engine sends each queued word on an SPI mode 0 link: the clock idles low, the chip select is low for the whole word, data goes out most significant bit first and changes on the falling edge, and the input line is sampled on the rising edge. The word captured from the input line goes into an eight-entry receive queue, where software reads it back from the same data register.

The engine takes a new word only while the port is enabled, slave mode is off, the transmit queue holds data and the receive queue has room. When the receive queue is full the engine stops, so received data is never lost. A loopback mode moves each transmit word straight into the receive queue and leaves the pins idle. Two queue-level interrupt sources, one per queue at the half-way point, are combined with a mask into a single level interrupt line.

Bus reads are registered: a read issued in one cycle returns its data on `bus_rdata` after the next rising clock edge, and a read of the data register removes the word at that edge. Writes take effect at the edge that samples them. Only word-aligned addresses are decoded.

Top module: `spi_fifo_master`

## Requirements
- R1: After reset the status register (word 0x0C) reads 0x03, the raw interrupt register (0x18) reads 0x08, the mask (0x14) and masked status (0x1C) read 0, `irq` is low, `cs_n` is high and `sclk` is low.
- R2: The word size is bits [3:0] of control register 0 (0x00) plus one; words written to the data register (0x08) are cut to that width, and words placed in the receive queue are cut to the width in force when they arrive.
- R3: The transmit queue holds 8 words; a data-register write while it holds 8 is dropped and the queue contents are unchanged.
- R4: A data-register read with an empty receive queue returns 0 and leaves the status register unchanged.
- R5: A word leaves the transmit queue only while enable (control register 1 at 0x04, bit 1) is set and the receive queue holds fewer than 8 words; otherwise the words wait and are later delivered in write order with none lost.
- R6: With loopback (control 1 bit 0) set, each transmitted word is returned unchanged as the received word and `cs_n` and `sclk` stay idle.
- R7: On the pins each word is sent most significant bit first; `sclk` stays high and low for P system cycles each, where P is the prescale register (0x10) value or 2 when that value is 0; `cs_n` is low for exactly 2*N*P cycles for an N-bit word, and `miso` is sampled on each rising `sclk`.
- R8: Status bits: bit 0 transmit queue empty, bit 1 transmit queue not full, bit 2 receive queue not empty, bit 3 receive queue full, bit 4 busy (transmit data waiting or a word in flight).
- R9: Raw interrupt bit 2 is set while the receive queue holds 4 or more words and bit 3 while the transmit queue holds 4 or fewer; masked status is raw AND mask, and `irq` is high exactly when that AND is non-zero.
- R10: The prescale register keeps only its low 8 bits; the DMA control word (0x20) reads 0 and ignores writes.
- R11: Words 0xFE0 to 0xFFC read the identification bytes 0x53, 0x4E, 0x69, 0x04, 0x27, 0xC2, 0xFD, 0x98 in address order; any other unmapped address reads 0.
- R12: While slave mode (control 1 bit 2) and enable are both set no word is transferred and the pins stay idle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Bus access request for this cycle |
| bus_wr | input | 1 | 1 for write, 0 for read |
| bus_addr | input | 12 | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after the read |
| irq | output | 1 | Level interrupt |
| sclk | output | 1 | Serial clock |
| cs_n | output | 1 | Chip select, active low |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |

## Verification
A wrong queue pointer or count shows at the data register as a word returned out of order, repeated or lost, and in the status and raw interrupt words read right after the writes, before any transfer completes. A wrong engine state shows on the pins within one word time as a chip-select window of the wrong length, a wrong rising-edge count or a wrong bit order, and in the received word as soon as the transfer ends. The stall and slave rules show as status that keeps its busy bit set and pins that never move.

// File: rtl/spi_fifo_pkg.sv
package spi_fifo_pkg;

    localparam int WORD_W = 16;
    localparam int SIZE_W = $clog2(WORD_W);

    // register word indices (byte address / 4)
    localparam logic [9:0] IDX_CTRL0  = 10'h000;
    localparam logic [9:0] IDX_CTRL1  = 10'h001;
    localparam logic [9:0] IDX_DATA   = 10'h002;
    localparam logic [9:0] IDX_STAT   = 10'h003;
    localparam logic [9:0] IDX_PRESC  = 10'h004;
    localparam logic [9:0] IDX_IMASK  = 10'h005;
    localparam logic [9:0] IDX_RAW    = 10'h006;
    localparam logic [9:0] IDX_MASKED = 10'h007;
    localparam logic [9:0] IDX_DMA    = 10'h008;

    typedef struct packed {
        logic busy;
        logic rx_full;
        logic rx_nempty;
        logic tx_nfull;
        logic tx_empty;
    } stat_t;

    typedef struct packed {
        logic sdo_off;
        logic slave;
        logic enable;
        logic loop;
    } ctrl1_t;

    typedef enum logic [1:0] {
        ENG_IDLE,
        ENG_LOW,
        ENG_HIGH
    } eng_state_e;

    function automatic logic [WORD_W-1:0] size_mask(input logic [SIZE_W-1:0] sz);
        logic [WORD_W:0] t;
        t = ((WORD_W+1)'(1) << ({1'b0, sz} + (SIZE_W+1)'(1))) - (WORD_W+1)'(1);
        return t[WORD_W-1:0];
    endfunction

    function automatic logic [7:0] id_byte(input logic [2:0] idx);
        logic [7:0] step;
        step = 8'({5'd0, idx} * 8'h1D);
        return step ^ 8'h53;
    endfunction

endpackage

// File: rtl/spi_word_fifo.sv
module spi_word_fifo #(
    parameter int W     = 16,
    parameter int DEPTH = 8
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       push,
    input  logic [W-1:0]               din,
    input  logic                       pop,
    output logic [W-1:0]               dout,
    output logic [$clog2(DEPTH+1)-1:0] count,
    output logic                       empty,
    output logic                       full
);
    localparam int PW = $clog2(DEPTH);
    localparam int CW = $clog2(DEPTH+1);

    logic [W-1:0]  mem [DEPTH];
    logic [PW-1:0] wr_ptr, rd_ptr;
    logic          do_push, do_pop;

    assign empty   = (count == '0);
    assign full    = (count == CW'(DEPTH));
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign dout    = mem[rd_ptr];

    function automatic logic [PW-1:0] nxt(input logic [PW-1:0] p);
        return (p == PW'(DEPTH-1)) ? '0 : p + PW'(1);
    endfunction

    always_ff @(posedge clk) begin
        if (do_push) mem[wr_ptr] <= din;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (do_push) wr_ptr <= nxt(wr_ptr);
            if (do_pop)  rd_ptr <= nxt(rd_ptr);
            case ({do_push, do_pop})
                2'b10:   count <= count + CW'(1);
                2'b01:   count <= count - CW'(1);
                default: count <= count;
            endcase
        end
    end

    // R3: a push into a full queue with no pop leaves the count alone
    p_full_drop_r3: assert property (@(posedge clk) disable iff (rst)
        (full && push && !pop) |=> (count == CW'(DEPTH)));

    // R4: popping an empty queue keeps it empty
    p_empty_pop_r4: assert property (@(posedge clk) disable iff (rst)
        (empty && pop && !push) |=> empty);

endmodule

// File: rtl/spi_shift_engine.sv
module spi_shift_engine import spi_fifo_pkg::*; #(
    parameter int W     = WORD_W,
    parameter int PRE_W = 8
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 start,
    input  logic [W-1:0]         tx_word,
    input  logic [$clog2(W)-1:0] nbits_m1,
    input  logic [PRE_W-1:0]     half,
    input  logic                 miso,
    output logic                 busy,
    output logic                 done,
    output logic [W-1:0]         rx_word,
    output logic                 sclk,
    output logic                 cs_n,
    output logic                 mosi
);
    localparam int BW = $clog2(W);

    eng_state_e       state;
    logic [PRE_W-1:0] cnt, half_q;
    logic [BW-1:0]    bits_left;
    logic [W-1:0]     tx_sh, rx_sh;
    logic             phase_end;

    assign phase_end = (cnt == '0);
    assign busy      = (state != ENG_IDLE);
    assign done      = (state == ENG_HIGH) && phase_end && (bits_left == '0);
    assign rx_word   = rx_sh;
    assign mosi      = busy ? tx_sh[W-1] : 1'b0;

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= ENG_IDLE;
            cnt       <= '0;
            half_q    <= '0;
            bits_left <= '0;
            tx_sh     <= '0;
            rx_sh     <= '0;
            sclk      <= 1'b0;
            cs_n      <= 1'b1;
        end else begin
            case (state)
                ENG_IDLE: begin
                    if (start) begin
                        state     <= ENG_LOW;
                        cs_n      <= 1'b0;
                        sclk      <= 1'b0;
                        half_q    <= half;
                        cnt       <= half - PRE_W'(1);
                        bits_left <= nbits_m1;
                        tx_sh     <= tx_word << (BW'(W-1) - nbits_m1);
                        rx_sh     <= '0;
                    end
                end
                ENG_LOW: begin
                    if (phase_end) begin
                        sclk  <= 1'b1;
                        rx_sh <= {rx_sh[W-2:0], miso};
                        cnt   <= half_q - PRE_W'(1);
                        state <= ENG_HIGH;
                    end else begin
                        cnt <= cnt - PRE_W'(1);
                    end
                end
                ENG_HIGH: begin
                    if (phase_end) begin
                        sclk <= 1'b0;
                        if (bits_left == '0) begin
                            state <= ENG_IDLE;
                            cs_n  <= 1'b1;
                        end else begin
                            bits_left <= bits_left - BW'(1);
                            tx_sh     <= tx_sh << 1;
                            cnt       <= half_q - PRE_W'(1);
                            state     <= ENG_LOW;
                        end
                    end else begin
                        cnt <= cnt - PRE_W'(1);
                    end
                end
                default: state <= ENG_IDLE;
            endcase
        end
    end

    // R7: the serial clock only toggles inside a chip-select window
    p_sclk_idle_r7: assert property (@(posedge clk) disable iff (rst)
        cs_n |-> !sclk);

    // R7: every rising serial clock falls inside a selected word
    p_rise_in_frame_r7: assert property (@(posedge clk) disable iff (rst)
        $rose(sclk) |-> !cs_n);

    // R7: output data holds still while the serial clock is high
    p_mosi_hold_r7: assert property (@(posedge clk) disable iff (rst)
        (sclk && $past(sclk)) |-> $stable(mosi));

endmodule

// File: rtl/spi_fifo_master.sv
module spi_fifo_master import spi_fifo_pkg::*; #(
    parameter int DEPTH = 8,
    parameter int PRE_W = 8
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        bus_sel,
    input  logic        bus_wr,
    input  logic [11:0] bus_addr,
    input  logic [31:0] bus_wdata,
    output logic [31:0] bus_rdata,
    output logic        irq,
    output logic        sclk,
    output logic        cs_n,
    output logic        mosi,
    input  logic        miso
);
    localparam int CW       = $clog2(DEPTH+1);
    localparam int HALF_LVL = DEPTH / 2;

    logic [31:0]       ctrl0;
    ctrl1_t            ctrl1;
    logic [PRE_W-1:0]  presc;
    logic [3:0]        imask;

    logic [9:0]        widx;
    logic              aligned, is_id;
    logic              wr_acc, rd_acc;
    logic [WORD_W-1:0] wmask;

    logic [WORD_W-1:0] tx_dout, rx_dout, rx_din, eng_rx;
    logic [CW-1:0]     tx_count, rx_count;
    logic              tx_empty, tx_full, rx_empty, rx_full;
    logic              tx_push, rx_push, rx_pop;
    logic              xfer_go, loop_go, eng_start, eng_busy, eng_done;
    logic [PRE_W-1:0]  half;
    logic [3:0]        raw, masked;
    stat_t             stat;
    logic [31:0]       rd_val;

    assign widx    = bus_addr[11:2];
    assign aligned = (bus_addr[1:0] == 2'b00);
    assign is_id   = aligned && (bus_addr[11:5] == 7'h7F);
    assign wr_acc  = bus_sel && bus_wr && aligned;
    assign rd_acc  = bus_sel && !bus_wr;
    assign wmask   = size_mask(ctrl0[SIZE_W-1:0]);
    assign half    = (presc == '0) ? PRE_W'(2) : presc;

    // ---------------- control registers ----------------
    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl0 <= '0;
            ctrl1 <= '0;
            presc <= '0;
            imask <= '0;
        end else if (wr_acc) begin
            case (widx)
                IDX_CTRL0: ctrl0 <= bus_wdata;
                IDX_CTRL1: ctrl1 <= ctrl1_t'(bus_wdata[3:0]);
                IDX_PRESC: presc <= bus_wdata[PRE_W-1:0];
                IDX_IMASK: imask <= bus_wdata[3:0];
                default: ;
            endcase
        end
    end

    // ---------------- queues ----------------
    assign tx_push = wr_acc && (widx == IDX_DATA);
    assign rx_pop  = rd_acc && aligned && (widx == IDX_DATA) && !rx_empty;

    assign xfer_go   = ctrl1.enable && !ctrl1.slave && !tx_empty && !rx_full && !eng_busy;
    assign loop_go   = xfer_go && ctrl1.loop;
    assign eng_start = xfer_go && !ctrl1.loop;
    assign rx_push   = loop_go || eng_done;
    assign rx_din    = (loop_go ? tx_dout : eng_rx) & wmask;

    spi_word_fifo #(.W(WORD_W), .DEPTH(DEPTH)) u_txq (
        .clk(clk), .rst(rst),
        .push(tx_push), .din(bus_wdata[WORD_W-1:0] & wmask),
        .pop(xfer_go), .dout(tx_dout),
        .count(tx_count), .empty(tx_empty), .full(tx_full)
    );

    spi_word_fifo #(.W(WORD_W), .DEPTH(DEPTH)) u_rxq (
        .clk(clk), .rst(rst),
        .push(rx_push), .din(rx_din),
        .pop(rx_pop), .dout(rx_dout),
        .count(rx_count), .empty(rx_empty), .full(rx_full)
    );

    // ---------------- serial engine ----------------
    spi_shift_engine #(.W(WORD_W), .PRE_W(PRE_W)) u_eng (
        .clk(clk), .rst(rst),
        .start(eng_start), .tx_word(tx_dout),
        .nbits_m1(ctrl0[SIZE_W-1:0]), .half(half),
        .miso(miso), .busy(eng_busy), .done(eng_done), .rx_word(eng_rx),
        .sclk(sclk), .cs_n(cs_n), .mosi(mosi)
    );

    // ---------------- status and interrupts ----------------
    assign stat.tx_empty  = tx_empty;
    assign stat.tx_nfull  = !tx_full;
    assign stat.rx_nempty = !rx_empty;
    assign stat.rx_full   = rx_full;
    assign stat.busy      = !tx_empty || eng_busy;

    assign raw    = {(tx_count <= CW'(HALF_LVL)), (rx_count >= CW'(HALF_LVL)), 2'b00};
    assign masked = raw & imask;
    assign irq    = |masked;

    // ---------------- read path ----------------
    always_comb begin
        rd_val = '0;
        if (is_id) begin
            rd_val = {24'd0, id_byte(bus_addr[4:2])};
        end else if (aligned) begin
            case (widx)
                IDX_CTRL0:  rd_val = ctrl0;
                IDX_CTRL1:  rd_val = {28'd0, ctrl1};
                IDX_DATA:   rd_val = rx_empty ? 32'd0 : {{(32-WORD_W){1'b0}}, rx_dout};
                IDX_STAT:   rd_val = {27'd0, stat};
                IDX_PRESC:  rd_val = {{(32-PRE_W){1'b0}}, presc};
                IDX_IMASK:  rd_val = {28'd0, imask};
                IDX_RAW:    rd_val = {28'd0, raw};
                IDX_MASKED: rd_val = {28'd0, masked};
                default:    rd_val = '0;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst)         bus_rdata <= '0;
        else if (rd_acc) bus_rdata <= rd_val;
    end

    // R5: a finished serial word always finds room in the receive queue
    p_no_rx_overrun_r5: assert property (@(posedge clk) disable iff (rst)
        eng_done |-> !rx_full);

    // R5: nothing leaves the transmit queue while the port is off
    p_off_holds_r5: assert property (@(posedge clk) disable iff (rst)
        (!ctrl1.enable && !tx_empty && !tx_push) |=> (tx_count == $past(tx_count)));

    // R12: slave setting keeps the chip select high
    p_slave_idle_r12: assert property (@(posedge clk) disable iff (rst)
        (ctrl1.slave && ctrl1.enable && !eng_busy) |=> cs_n);

    // R9: receive level with its mask bit raises the line
    p_irq_rx_r9: assert property (@(posedge clk) disable iff (rst)
        ((rx_count >= CW'(HALF_LVL)) && imask[2]) |-> irq);

    // R6: loopback traffic never drives the chip select
    p_loop_pins_r6: assert property (@(posedge clk) disable iff (rst)
        (ctrl1.loop && !eng_busy) |=> cs_n);

endmodule

// File: tb/spi_fifo_master_tb.sv
module spi_fifo_master_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_sel = 1'b0, bus_wr = 1'b0;
    logic [11:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq, sclk, cs_n, mosi, miso;
    logic        inv = 1'b0;

    int checks = 0, failures = 0, cyc = 0;
    int cs_low = 0, rises = 0;
    logic        pin_act = 1'b0;
    logic [15:0] cap = '0;

    always #10 clk = ~clk;   // 50 MHz
    assign miso = mosi ^ inv;

    spi_fifo_master u_dut (
        .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq(irq), .sclk(sclk), .cs_n(cs_n), .mosi(mosi), .miso(miso)
    );

    always @(negedge clk) begin
        if (!cs_n) cs_low++;
        if (!cs_n || sclk) pin_act = 1'b1;
    end
    always @(posedge sclk) begin
        rises++;
        cap = {cap[14:0], mosi};
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc == 150000) begin
            checks++; failures++;
            $display("FAIL watchdog expired");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [11:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        @(negedge clk);
        bus_sel = 1'b0;
        d = bus_rdata;
    endtask

    task automatic wait_idle();
        logic [31:0] s;
        for (int i = 0; i < 20000; i++) begin
            rd(12'h00C, s);
            if (s[4] == 1'b0) break;
        end
    endtask

    function automatic logic [15:0] mask_of(input int sz);
        return 16'((32'd1 << (sz + 1)) - 1);
    endfunction

    function automatic logic [15:0] expect_rx(input logic [15:0] w, input int sz,
                                              input bit lb, input bit iv);
        logic [15:0] m;
        m = mask_of(sz);
        return (lb || !iv) ? (w & m) : (~w & m);
    endfunction

    logic [31:0] v;
    logic [15:0] words [8];
    logic [7:0]  ids [8] = '{8'h53, 8'h4E, 8'h69, 8'h04, 8'h27, 8'hC2, 8'hFD, 8'h98};

    initial begin
        void'($urandom(32'd2024));
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        rd(12'h00C, v); chk("R1 status", v, 32'h03);
        rd(12'h018, v); chk("R1 raw", v, 32'h08);
        rd(12'h014, v); chk("R1 mask", v, 32'h0);
        rd(12'h01C, v); chk("R1 masked", v, 32'h0);
        chk("R1 pins", {29'd0, irq, cs_n, sclk}, 32'h2);

        // R4 empty read
        rd(12'h008, v); chk("R4 empty read", v, 32'h0);
        rd(12'h00C, v); chk("R4 status unchanged", v, 32'h03);

        // R10 prescale and DMA word
        wr(12'h010, 32'h1FF); rd(12'h010, v); chk("R10 prescale", v, 32'hFF);
        wr(12'h020, 32'hFFFF); rd(12'h020, v); chk("R10 dma", v, 32'h0);

        // R11 id bytes and unmapped space
        for (int i = 0; i < 8; i++) begin
            rd(12'hFE0 + 12'(i * 4), v); chk("R11 id", v, {24'd0, ids[i]});
        end
        rd(12'h024, v); chk("R11 unmapped", v, 32'h0);
        rd(12'h800, v); chk("R11 unmapped", v, 32'h0);

        // R5/R8/R9 disabled port: five words wait
        wr(12'h000, 32'd15); wr(12'h010, 32'd1); wr(12'h004, 32'h0);
        for (int i = 0; i < 5; i++) wr(12'h008, 32'h100 + 32'(i));
        repeat (50) @(negedge clk);
        rd(12'h00C, v); chk("R5 R8 disabled holds", v, 32'h12);
        rd(12'h018, v); chk("R9 raw five tx", v, 32'h0);
        wr(12'h014, 32'h4);
        chk("R9 irq low", {31'd0, irq}, 32'h0);
        pin_act = 1'b0;
        wr(12'h004, 32'h3);   // enable + loopback
        wait_idle();
        chk("R6 pins idle", {31'd0, pin_act}, 32'h0);
        rd(12'h018, v); chk("R9 raw levels", v, 32'h0C);
        rd(12'h01C, v); chk("R9 masked", v, 32'h04);
        chk("R9 irq high", {31'd0, irq}, 32'h1);
        for (int i = 0; i < 5; i++) begin
            rd(12'h008, v); chk("R6 loop data", v, 32'h100 + 32'(i));
        end
        wr(12'h014, 32'h0);

        // R2 width cut
        wr(12'h000, 32'd3); wr(12'h008, 32'hABCD);
        wait_idle(); rd(12'h008, v); chk("R2 four-bit word", v, 32'hD);

        // R3 + R5 receive-full stall
        wr(12'h000, 32'd7); wr(12'h004, 32'h0);
        for (int i = 0; i < 9; i++) wr(12'h008, 32'(i + 1));
        rd(12'h00C, v); chk("R3 tx full", v, 32'h10);
        wr(12'h004, 32'h3);
        repeat (20) @(negedge clk);
        for (int i = 0; i < 3; i++) wr(12'h008, 32'h40 + 32'(i));
        repeat (50) @(negedge clk);
        rd(12'h00C, v); chk("R5 R8 rx full stall", v, 32'h1E);
        rd(12'h018, v); chk("R9 stall levels", v, 32'h0C);
        for (int i = 0; i < 8; i++) begin
            rd(12'h008, v); chk("R3 R5 order", v, 32'(i + 1));
        end
        wait_idle();
        for (int i = 0; i < 3; i++) begin
            rd(12'h008, v); chk("R5 resumed", v, 32'h40 + 32'(i));
        end
        rd(12'h00C, v); chk("R8 drained", v, 32'h03);

        // R12 slave mode
        pin_act = 1'b0;
        wr(12'h004, 32'h6); wr(12'h008, 32'h77);
        repeat (200) @(negedge clk);
        rd(12'h00C, v); chk("R12 no transfer", v, 32'h12);
        chk("R12 pins idle", {31'd0, pin_act}, 32'h0);
        wr(12'h004, 32'h2);
        wait_idle(); rd(12'h008, v); chk("R12 released", v, 32'h77);

        // R7 pin timing and bit order
        inv = 1'b1; cs_low = 0; rises = 0;
        wr(12'h010, 32'd3);
        wr(12'h008, 32'hA5);
        wait_idle();
        chk("R7 cs window", 32'(cs_low), 32'd48);
        chk("R7 rising edges", 32'(rises), 32'd8);
        chk("R7 msb first", {24'd0, cap[7:0]}, 32'hA5);
        rd(12'h008, v); chk("R7 sampled miso", v, 32'h5A);
        cs_low = 0;
        wr(12'h010, 32'd0); wr(12'h008, 32'h01);
        wait_idle(); rd(12'h008, v);
        chk("R7 zero prescale", 32'(cs_low), 32'd32);

        // random traffic
        for (int it = 0; it < 30; it++) begin
            int sz, n;
            bit lb, iv;
            sz = 3 + int'($urandom % 13);
            n  = 1 + int'($urandom % 8);
            lb = 1'($urandom % 2);
            iv = 1'($urandom % 2);
            inv = iv;
            wr(12'h000, 32'(sz));
            wr(12'h010, $urandom % 4);
            wr(12'h004, lb ? 32'h3 : 32'h2);
            for (int k = 0; k < n; k++) begin
                words[k] = 16'($urandom);
                wr(12'h008, {16'($urandom), words[k]});
            end
            wait_idle();
            for (int k = 0; k < n; k++) begin
                rd(12'h008, v);
                chk("R2 R6 R7 random word", v, {16'd0, expect_rx(words[k], sz, lb, iv)});
            end
            rd(12'h00C, v); chk("R8 random idle", v, 32'h03);
        end

        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule